// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

A four-bit synchronous counter that counts either through sixteen states (binary) or through ten states (decade), upward or downward, selected at run time by two level inputs. An active-low chain input works as a count enable. An active-high jam enable loads the count from a four-bit jam value immediately, without waiting for a clock edge. Driving all jam bits low while the jam enable is high clears the counter.

An active-low chain output is decoded straight from the current count, the two mode inputs and the chain input. It goes low at the terminal count when the chain input is low. The terminal count is the top value when counting up and zero when counting down. Because the decode is combinational, several counters on one clock can be chained with look-ahead carry: each stage's chain output drives the next stage's chain input. The result is a wider binary counter or a multi-digit decimal counter.

Top module: `updown_jam_counter`

## Requirements
- R1: A rising jam_en loads count from jam_val at once, with no clock edge; jam_val = 4'b0000 gives count 0.
- R2: While jam_en stays high, clock edges do not count; at each edge count takes the present jam_val.
- R3: With jam_en low and chain_in_n low, each rising clock edge moves count by exactly one step.
- R4: With chain_in_n high, count keeps its value across clock edges.
- R5: With bin_mode = 1 the modulus is 16: up from 15 gives 0, down from 0 gives 15.
- R6: With bin_mode = 0 the modulus is 10: up from 9 gives 0, down from 0 gives 9.
- R7: In decade mode, a count of 10 to 15 goes to 0 when counting up and to count minus 1 when counting down; chain_out_n stays high for these values.
- R8: count_up = 1 selects counting up; count_up = 0 selects counting down.
- R9: chain_out_n is low only when chain_in_n is low and count is at its terminal value: 15 (binary) or 9 (decade) when counting up, 0 when counting down. Otherwise it is high.
- R10: chain_out_n follows changes of bin_mode, count_up and chain_in_n with no clock edge in between.
- R11: Two instances on one clock, with the low stage's chain_out_n driving the high stage's chain_in_n, count as an 8-bit binary counter or as a 2-digit decimal counter, upward or downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| jam_en | input | 1 | Asynchronous load of jam_val while high |
| jam_val | input | 4 | Load value |
| chain_in_n | input | 1 | Active-low count enable / carry input |
| bin_mode | input | 1 | 1 = modulus 16, 0 = modulus 10 |
| count_up | input | 1 | 1 = up, 0 = down |
| count | output | 4 | Current count |
| chain_out_n | output | 1 | Active-low terminal-count carry |

## Verification
The assertions check every cycle that single steps go in the right direction, that the count holds while the chain input is high, that both moduli wrap, that out-of-range decade values step correctly, that the chain output only goes low at a terminal value, and that a held jam enable tracks the jam value. The bench's scenarios are needed for behaviour between clock edges: the load with no clock, and the chain output reacting to a mode change. The scenarios also cover the two chained instances, which form an 8-bit binary counter and a 2-digit decimal counter. A behavioural model in the bench checks these against the counter on every clock.

// File: rtl/ujc_pkg.sv
package ujc_pkg;
  localparam int CW       = 4;
  localparam int BIN_LAST = (1 << CW) - 1;
  localparam int DEC_LAST = 9;
  typedef logic [CW-1:0] cnt_t;

  // highest value of the selected modulus
  function automatic cnt_t last_of(logic bin);
    return bin ? cnt_t'(BIN_LAST) : cnt_t'(DEC_LAST);
  endfunction

  // value after one counting step
  function automatic cnt_t step_value(cnt_t q, logic bin, logic up);
    cnt_t r;
    if (up) r = (q >= last_of(bin)) ? '0 : cnt_t'(q + 1'b1);
    else    r = (q == '0) ? last_of(bin) : cnt_t'(q - 1'b1);
    return r;
  endfunction

  // terminal value for the present direction
  function automatic logic is_terminal(cnt_t q, logic bin, logic up);
    return up ? (q == last_of(bin)) : (q == '0);
  endfunction
endpackage

// File: rtl/ujc_next.sv
module ujc_next
  import ujc_pkg::*;
(
  input  cnt_t q,
  input  logic bin_mode,
  input  logic count_up,
  output cnt_t nxt
);
  always_comb nxt = step_value(q, bin_mode, count_up);
endmodule

// File: rtl/ujc_terminal.sv
module ujc_terminal
  import ujc_pkg::*;
(
  input  cnt_t q,
  input  logic bin_mode,
  input  logic count_up,
  input  logic chain_in_n,
  output logic term_hit,
  output logic chain_out_n
);
  always_comb begin
    term_hit    = is_terminal(q, bin_mode, count_up);
    chain_out_n = ~(term_hit & ~chain_in_n);
  end
endmodule

// File: rtl/ujc_state.sv
module ujc_state
  import ujc_pkg::*;
(
  input  logic clk,
  input  logic jam_en,
  input  cnt_t jam_val,
  input  logic adv,
  input  cnt_t nxt,
  output cnt_t q
);
  always_ff @(posedge clk or posedge jam_en) begin
    if (jam_en)   q <= jam_val;
    else if (adv) q <= nxt;
  end
endmodule

// File: rtl/updown_jam_counter.sv
module updown_jam_counter
  import ujc_pkg::*;
(
  input  logic          clk,
  input  logic          jam_en,
  input  logic [CW-1:0] jam_val,
  input  logic          chain_in_n,
  input  logic          bin_mode,
  input  logic          count_up,
  output logic [CW-1:0] count,
  output logic          chain_out_n
);
  // named internal events, observed by the checker
  logic adv;
  logic term_hit;
  cnt_t nxt;
  cnt_t q;

  assign adv   = ~chain_in_n & ~jam_en;
  assign count = q;

  ujc_next u_next (
    .q(q), .bin_mode(bin_mode), .count_up(count_up), .nxt(nxt)
  );

  ujc_terminal u_term (
    .q(q), .bin_mode(bin_mode), .count_up(count_up), .chain_in_n(chain_in_n),
    .term_hit(term_hit), .chain_out_n(chain_out_n)
  );

  ujc_state u_state (
    .clk(clk), .jam_en(jam_en), .jam_val(jam_val), .adv(adv), .nxt(nxt), .q(q)
  );
endmodule

// File: rtl/ujc_checker.sv
module ujc_checker
  import ujc_pkg::*;
(
  input logic          clk,
  input logic          jam_en,
  input logic [CW-1:0] jam_val,
  input logic          chain_in_n,
  input logic          bin_mode,
  input logic          count_up,
  input logic [CW-1:0] count,
  input logic          chain_out_n,
  input logic          adv
);
  p_preset_track_r2: assert property (@(posedge clk)
    (jam_en && $past(jam_en) && $stable(jam_val)) |-> (count == jam_val));

  p_hold_r4: assert property (@(posedge clk) disable iff (jam_en)
    chain_in_n |=> $stable(count));

  p_step_down_r3: assert property (@(posedge clk) disable iff (jam_en)
    (adv && !count_up && count != '0) |=> (count == CW'($past(count) - 1'b1)));

  p_bin_up_r5: assert property (@(posedge clk) disable iff (jam_en)
    (adv && bin_mode && count_up) |=> (count == CW'($past(count) + 1'b1)));

  p_dec_wrap_r6: assert property (@(posedge clk) disable iff (jam_en)
    (adv && !bin_mode && !count_up && count == '0) |=> (count == CW'(DEC_LAST)));

  p_dec_over_r7: assert property (@(posedge clk) disable iff (jam_en)
    (adv && !bin_mode && count_up && count > CW'(DEC_LAST)) |=> (count == '0));

  p_cout_gated_r9: assert property (@(posedge clk) disable iff (jam_en)
    !chain_out_n |-> (!chain_in_n && (count == '0 || count == CW'(DEC_LAST)
                                      || count == CW'(BIN_LAST))));

  p_cout_top_r9: assert property (@(posedge clk) disable iff (jam_en)
    (!chain_in_n && bin_mode && count_up && count == CW'(BIN_LAST)) |-> !chain_out_n);
endmodule

bind updown_jam_counter ujc_checker u_chk (
  .clk(clk), .jam_en(jam_en), .jam_val(jam_val), .chain_in_n(chain_in_n),
  .bin_mode(bin_mode), .count_up(count_up), .count(count),
  .chain_out_n(chain_out_n), .adv(adv)
);

// File: tb/updown_jam_counter_tb.sv
`timescale 1ns/1ps
module updown_jam_counter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // primary instance
  logic       jam_en = 1'b0;
  logic [3:0] jam_val = 4'd0;
  logic       cin_n = 1'b0, bin = 1'b1, up = 1'b1;
  logic [3:0] cnt;
  logic       cout_n;

  updown_jam_counter u_dut (
    .clk(clk), .jam_en(jam_en), .jam_val(jam_val), .chain_in_n(cin_n),
    .bin_mode(bin), .count_up(up), .count(cnt), .chain_out_n(cout_n)
  );

  // two chained instances
  logic       c_jam = 1'b0, c_bin = 1'b1, c_up = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  updown_jam_counter u_lo (
    .clk(clk), .jam_en(c_jam), .jam_val(4'd0), .chain_in_n(1'b0),
    .bin_mode(c_bin), .count_up(c_up), .count(lo_q), .chain_out_n(lo_co)
  );
  updown_jam_counter u_hi (
    .clk(clk), .jam_en(c_jam), .jam_val(4'd0), .chain_in_n(lo_co),
    .bin_mode(c_bin), .count_up(c_up), .count(hi_q), .chain_out_n(hi_co)
  );

  // behavioural models
  int m = 0;
  int n = 0;

  function automatic int modulus(logic b);
    return b ? 16 : 10;
  endfunction

  function automatic int model_next(int v, logic b, logic u);
    int md = modulus(b);
    if (u) return (v >= md) ? 0 : (v + 1) % md;
    return (v == 0) ? md - 1 : v - 1;
  endfunction

  function automatic logic model_cout(int v, logic b, logic u, logic ci);
    logic at_end = u ? (v == modulus(b) - 1) : (v == 0);
    return (ci == 1'b0 && at_end) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_dut(string tag);
    chk(tag, cnt, m);
    chk({tag, " carry"}, cout_n, model_cout(m, bin, up, cin_n));
  endtask

  // one clock for the primary instance, compare after the edge
  task automatic tick(string tag);
    @(posedge clk);
    if (jam_en) m = jam_val;
    else if (!cin_n) m = model_next(m, bin, up);
    @(negedge clk);
    check_dut(tag);
  endtask

  task automatic async_load(int v);
    @(negedge clk);
    jam_val = 4'(v);
    jam_en  = 1'b1;
    m = v;
    #1;
    chk("R1 load without clock", cnt, v);
    @(negedge clk);
    jam_en = 1'b0;
    #0.5;
  endtask

  task automatic chain_tick(string tag, logic decimal);
    @(posedge clk);
    if (!c_jam) begin
      if (decimal) n = c_up ? (n + 1) % 100 : (n + 99) % 100;
      else         n = c_up ? (n + 1) % 256 : (n + 255) % 256;
    end
    @(negedge clk);
    if (decimal) chk(tag, hi_q * 10 + lo_q, n);
    else         chk(tag, hi_q * 16 + lo_q, n);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: rising jam enable with all-zero jam value clears
    #1;
    jam_en = 1'b1; c_jam = 1'b1;
    m = 0;
    #0.5;
    chk("R1 zero jam", cnt, 0);

    // R2: held jam enable blocks counting and tracks jam value
    tick("R2 held jam");
    tick("R2 held jam");
    @(negedge clk); jam_val = 4'd7; m = 7;
    tick("R2 jam change");
    @(negedge clk); jam_en = 1'b0;

    // R3 R5 R8: binary up through a wrap
    bin = 1'b1; up = 1'b1;
    for (int i = 0; i < 20; i++) tick("R5 binary up");
    // R8: binary down through a wrap
    up = 1'b0;
    for (int i = 0; i < 20; i++) tick("R8 binary down");

    // R4: hold with chain input high, carry forced high
    cin_n = 1'b1;
    for (int i = 0; i < 5; i++) tick("R4 hold");
    cin_n = 1'b0;

    // R6: decade both directions
    async_load(0);
    bin = 1'b0; up = 1'b1;
    for (int i = 0; i < 25; i++) tick("R6 decade up");
    up = 1'b0;
    for (int i = 0; i < 25; i++) tick("R6 decade down");

    // R7: out-of-range decade values
    async_load(13);
    up = 1'b1; #0.5;
    chk("R7 no carry at 13", cout_n, 1);
    tick("R7 decade up from 13");
    chk("R7 up from 13", cnt, 0);
    async_load(13);
    up = 1'b0; #0.5;
    chk("R7 no carry at 13 down", cout_n, 1);
    tick("R7 decade down from 13");
    chk("R7 down from 13", cnt, 12);

    // R9 R10: carry follows mode inputs without a clock
    async_load(9);
    bin = 1'b0; up = 1'b1; #0.5;
    chk("R9 carry at 9 decade up", cout_n, 0);
    bin = 1'b1; #0.5;
    chk("R10 carry after binary select", cout_n, 1);
    bin = 1'b0; #0.5;
    chk("R10 carry after decade select", cout_n, 0);
    cin_n = 1'b1; #0.5;
    chk("R10 carry gated by chain input", cout_n, 1);
    cin_n = 1'b0;
    async_load(0);
    up = 1'b0; #0.5;
    chk("R9 carry at 0 down", cout_n, 0);
    up = 1'b1; #0.5;
    chk("R10 carry after direction change", cout_n, 1);

    // R11: chained 8-bit binary up and down
    @(negedge clk); c_jam = 1'b1; c_bin = 1'b1; c_up = 1'b1; n = 0;
    @(negedge clk); c_jam = 1'b0;
    for (int i = 0; i < 300; i++) chain_tick("R11 8-bit up", 1'b0);
    c_up = 1'b0;
    for (int i = 0; i < 60; i++) chain_tick("R11 8-bit down", 1'b0);

    // R11: chained 2-digit decimal up and down
    @(negedge clk); c_jam = 1'b1; c_bin = 1'b0; c_up = 1'b1; n = 0;
    @(negedge clk); c_jam = 1'b0;
    for (int i = 0; i < 120; i++) chain_tick("R11 BCD up", 1'b1);
    c_up = 1'b0;
    for (int i = 0; i < 120; i++) chain_tick("R11 BCD down", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule